// File: doc/BRIEF.md
# PCI Interrupt Router and Trigger

This block turns a legacy PCI interrupt request, identified by the slot of the device that raised it and the INTx pin it used (0 for INTA through 3 for INTD), into an internal interrupt number. It then drives one interrupt line towards the CPU. The number is found with a fixed, slot-dependent swizzle. Every translated number lies above a base of 32, and slots outside the known set pass the pin number through unchanged.

Each internal interrupt source at or above the base owns one bit in two configuration masks. The bit position is the mapped number minus 32. If the source's bit in the edge mask is set, the request produces a single-cycle pulse on the CPU line. If it is clear, the request sets the line to the value of the source's bit in the polarity mask, and the line keeps that value until a later request changes it. A request whose index falls outside the mask does not touch the line.

The block is a two-stage pipeline. The translation is registered first, and the trigger stage registers the CPU line one cycle later.

Top module: `pciirq_router`

## Requirements
- R1: While reset is held and on the first cycle after it, `cpu_irq_o` and `map_valid_o` are 0 and `map_num_o` is 0.
- R2: A request presented with `req_valid_i` high at a clock edge makes `map_valid_o` high for exactly the following cycle, with `map_num_o` holding its translation. Without a request, `map_valid_o` is low.
- R3: Slot 5 translates to 32 + pin (the pin taken modulo 4).
- R4: Slot 6 translates to 36 and slot 7 translates to 37, whatever the pin.
- R5: Slots 8 to 12 translate to 38 + (slot − 8) + pin.
- R6: Every other slot translates to the bare pin number (0 to 3).
- R7: Let index = `map_num_o` − 32, taken in the cycle `map_valid_o` is high, and suppose it lies in 0..31 with `edge_mask_i[index]` set. Then `cpu_irq_o` is 1 in the next cycle and returns to 0 one cycle later, unless another request arrives in that cycle.
- R8: For an in-range index whose edge bit is clear, `cpu_irq_o` takes `pol_mask_i[index]` in the next cycle. It keeps that value while no further request arrives.
- R9: A request whose index lies outside 0..31 leaves `cpu_irq_o` at its level. A single-cycle pulse already on the line still ends on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Interrupt request strobe |
| req_slot_i | input | SLOT_W | Slot of the requesting device |
| req_pin_i | input | 2 | INTx pin of the request (0..3) |
| edge_mask_i | input | SRC_N | Per-source edge selection (bit = mapped − 32) |
| pol_mask_i | input | SRC_N | Per-source level value used when edge bit is clear |
| map_valid_o | output | 1 | Translated number is valid this cycle |
| map_num_o | output | NUM_W | Translated interrupt number |
| cpu_irq_o | output | 1 | Interrupt line towards the CPU |

## Verification
The checker watches the pipeline latency on every cycle, along with the fixed translations of slots 5, 6 and 7. It also checks the trigger stage's reaction to each mapped request: the pulse rising after an edge source, the pulse ending in the cycle after, the level following the polarity bit, and the line staying put for out-of-range numbers. Other behaviour shows up only in the bench's directed scenarios. That covers the full translation of slots 8 to 12 and of unknown slots, a level that is held across idle cycles, and back-to-back requests where a level request overrides the end of a pulse. It also covers a pulse fired while the line is already high by level, which leaves the line low.

// File: rtl/pciirq_pkg.sv
package pciirq_pkg;

  // Width of an INTx pin number (INTA..INTD).
  localparam int PIN_W = 2;

  // Slots with fixed routing.
  localparam int SLOT_SOUTH  = 5;
  localparam int SLOT_VIDEO  = 6;
  localparam int SLOT_NET    = 7;
  localparam int SLOT_EXP_LO = 8;
  localparam int SLOT_EXP_HI = 12;

  // Offsets above the interrupt base for each routed group.
  localparam int OFS_VIDEO = 4;
  localparam int OFS_NET   = 5;
  localparam int OFS_EXP   = 6;

endpackage

// File: rtl/pciirq_swizzle.sv
module pciirq_swizzle
  import pciirq_pkg::*;
#(
  parameter int SLOT_W   = 5,
  parameter int NUM_W    = 8,
  parameter int IRQ_BASE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [SLOT_W-1:0] req_slot_i,
  input  logic [PIN_W-1:0]  req_pin_i,
  output logic              map_valid_o,
  output logic [NUM_W-1:0]  map_num_o
);

  localparam logic [NUM_W-1:0] BASE_N   = NUM_W'(IRQ_BASE);
  localparam logic [NUM_W-1:0] EXP_LO_N = NUM_W'(SLOT_EXP_LO);

  logic [NUM_W-1:0] slot_ext;
  logic [NUM_W-1:0] pin_ext;
  logic [NUM_W-1:0] num_c;
  logic             is_exp;

  always_comb begin
    slot_ext = NUM_W'(req_slot_i);
    pin_ext  = NUM_W'(req_pin_i[1:0]);
    is_exp   = (slot_ext >= EXP_LO_N) && (slot_ext <= NUM_W'(SLOT_EXP_HI));
    if (slot_ext == NUM_W'(SLOT_SOUTH)) begin
      num_c = BASE_N + pin_ext;
    end else if (slot_ext == NUM_W'(SLOT_VIDEO)) begin
      num_c = BASE_N + NUM_W'(OFS_VIDEO);
    end else if (slot_ext == NUM_W'(SLOT_NET)) begin
      num_c = BASE_N + NUM_W'(OFS_NET);
    end else if (is_exp) begin
      num_c = BASE_N + NUM_W'(OFS_EXP) + (slot_ext - EXP_LO_N) + pin_ext;
    end else begin
      num_c = pin_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_valid_o <= 1'b0;
      map_num_o   <= '0;
    end else begin
      map_valid_o <= req_valid_i;
      if (req_valid_i) begin
        map_num_o <= num_c;
      end
    end
  end

endmodule

// File: rtl/pciirq_trigger.sv
module pciirq_trigger #(
  parameter int NUM_W    = 8,
  parameter int IRQ_BASE = 32,
  parameter int SRC_N    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             map_valid_i,
  input  logic [NUM_W-1:0] map_num_i,
  input  logic [SRC_N-1:0] edge_mask_i,
  input  logic [SRC_N-1:0] pol_mask_i,
  output logic             cpu_irq_o
);

  localparam int IDX_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;

  logic [NUM_W-1:0] offset;
  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             pulse_q;

  always_comb begin
    offset   = map_num_i - NUM_W'(IRQ_BASE);
    in_range = (map_num_i >= NUM_W'(IRQ_BASE)) && (offset < NUM_W'(SRC_N));
    idx      = IDX_W'(offset);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq_o <= 1'b0;
      pulse_q   <= 1'b0;
    end else if (map_valid_i && in_range) begin
      if (edge_mask_i[idx]) begin
        cpu_irq_o <= 1'b1;
        pulse_q   <= 1'b1;
      end else begin
        cpu_irq_o <= pol_mask_i[idx];
        pulse_q   <= 1'b0;
      end
    end else if (pulse_q) begin
      cpu_irq_o <= 1'b0;
      pulse_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/pciirq_router.sv
module pciirq_router
  import pciirq_pkg::*;
#(
  parameter int SLOT_W   = 5,
  parameter int NUM_W    = 8,
  parameter int IRQ_BASE = 32,
  parameter int SRC_N    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [SLOT_W-1:0] req_slot_i,
  input  logic [PIN_W-1:0]  req_pin_i,
  input  logic [SRC_N-1:0]  edge_mask_i,
  input  logic [SRC_N-1:0]  pol_mask_i,
  output logic              map_valid_o,
  output logic [NUM_W-1:0]  map_num_o,
  output logic              cpu_irq_o
);

  logic             swz_valid;
  logic [NUM_W-1:0] swz_num;

  pciirq_swizzle #(
    .SLOT_W  (SLOT_W),
    .NUM_W   (NUM_W),
    .IRQ_BASE(IRQ_BASE)
  ) u_swizzle (
    .clk        (clk),
    .rst        (rst),
    .req_valid_i(req_valid_i),
    .req_slot_i (req_slot_i),
    .req_pin_i  (req_pin_i),
    .map_valid_o(swz_valid),
    .map_num_o  (swz_num)
  );

  pciirq_trigger #(
    .NUM_W   (NUM_W),
    .IRQ_BASE(IRQ_BASE),
    .SRC_N   (SRC_N)
  ) u_trigger (
    .clk        (clk),
    .rst        (rst),
    .map_valid_i(swz_valid),
    .map_num_i  (swz_num),
    .edge_mask_i(edge_mask_i),
    .pol_mask_i (pol_mask_i),
    .cpu_irq_o  (cpu_irq_o)
  );

  assign map_valid_o = swz_valid;
  assign map_num_o   = swz_num;

endmodule

// File: rtl/pciirq_router_chk.sv
module pciirq_router_chk #(
  parameter int SLOT_W   = 5,
  parameter int NUM_W    = 8,
  parameter int IRQ_BASE = 32,
  parameter int SRC_N    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic [SLOT_W-1:0] req_slot_i,
  input logic [1:0]        req_pin_i,
  input logic [SRC_N-1:0]  edge_mask_i,
  input logic [SRC_N-1:0]  pol_mask_i,
  input logic              map_valid_o,
  input logic [NUM_W-1:0]  map_num_o,
  input logic              cpu_irq_o
);

  localparam int IDX_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;

  logic [NUM_W-1:0] ofs;
  logic             inr;
  logic             sel_edge;
  logic             sel_pol;

  always_comb begin
    ofs      = map_num_o - NUM_W'(IRQ_BASE);
    inr      = (map_num_o >= NUM_W'(IRQ_BASE)) && (ofs < NUM_W'(SRC_N));
    sel_edge = edge_mask_i[IDX_W'(ofs)];
    sel_pol  = pol_mask_i[IDX_W'(ofs)];
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!cpu_irq_o && !map_valid_o && map_num_o == '0));

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> map_valid_o);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !map_valid_o);

  // R3
  south_map_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_slot_i == SLOT_W'(5)) |=>
      (map_num_o == NUM_W'(IRQ_BASE) + NUM_W'($past(req_pin_i))));

  // R4
  video_map_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_slot_i == SLOT_W'(6)) |=> (map_num_o == NUM_W'(IRQ_BASE + 4)));

  // R4
  net_map_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_slot_i == SLOT_W'(7)) |=> (map_num_o == NUM_W'(IRQ_BASE + 5)));

  // R7
  pulse_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (map_valid_o && inr && sel_edge) |=> cpu_irq_o);

  // R7
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    (map_valid_o && inr && sel_edge) ##1 !map_valid_o |=> !cpu_irq_o);

  // R8
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (map_valid_o && inr && !sel_edge) |=> (cpu_irq_o == $past(sel_pol)));

  // R9
  out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    (map_valid_o && !inr && !cpu_irq_o) |=> !cpu_irq_o);

  // R9
  idle_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !(map_valid_o && inr) |=> !$rose(cpu_irq_o));

endmodule

bind pciirq_router pciirq_router_chk #(
  .SLOT_W  (SLOT_W),
  .NUM_W   (NUM_W),
  .IRQ_BASE(IRQ_BASE),
  .SRC_N   (SRC_N)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid_i(req_valid_i),
  .req_slot_i (req_slot_i),
  .req_pin_i  (req_pin_i),
  .edge_mask_i(edge_mask_i),
  .pol_mask_i (pol_mask_i),
  .map_valid_o(map_valid_o),
  .map_num_o  (map_num_o),
  .cpu_irq_o  (cpu_irq_o)
);

// File: tb/pciirq_router_bench.sv
`timescale 1ns/1ps
module pciirq_router_bench;

  localparam int SLOT_W = 5;
  localparam int NUM_W  = 8;
  localparam int SRC_N  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid_i = 1'b0;
  logic [SLOT_W-1:0] req_slot_i = '0;
  logic [1:0]        req_pin_i = '0;
  logic [SRC_N-1:0]  edge_mask_i = '0;
  logic [SRC_N-1:0]  pol_mask_i = '0;
  logic              map_valid_o;
  logic [NUM_W-1:0]  map_num_o;
  logic              cpu_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pciirq_router #(.SLOT_W(SLOT_W), .NUM_W(NUM_W), .IRQ_BASE(32), .SRC_N(SRC_N)) u_pciirq_router (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_slot_i(req_slot_i),
    .req_pin_i(req_pin_i), .edge_mask_i(edge_mask_i), .pol_mask_i(pol_mask_i),
    .map_valid_o(map_valid_o), .map_num_o(map_num_o), .cpu_irq_o(cpu_irq_o)
  );

  function automatic int exp_map(int slot, int pin);
    if (slot == 5) return 32 + (pin % 4);
    if (slot == 6) return 36;
    if (slot == 7) return 37;
    if (slot >= 8 && slot <= 12) return 38 + (slot - 8) + pin;
    return pin;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Present a request at the next edge; returns just after that edge.
  task automatic issue(int slot, int pin);
    req_valid_i = 1'b1;
    req_slot_i  = SLOT_W'(slot);
    req_pin_i   = 2'(pin);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic map_and_check(int slot, int pin, string tag);
    issue(slot, pin);
    check({tag, " valid"}, int'(map_valid_o), 1);
    check({tag, " num"}, int'(map_num_o), exp_map(slot, pin));
    @(negedge clk);
    check("R2 valid drops", int'(map_valid_o), 0);
  endtask

  task automatic t_reset();
    check("R1 cpu_irq", int'(cpu_irq_o), 0);
    check("R1 map_valid", int'(map_valid_o), 0);
    check("R1 map_num", int'(map_num_o), 0);
  endtask

  task automatic t_south();
    for (int p = 0; p < 4; p++) map_and_check(5, p, "R3 slot5");
    check("R3 line untouched (level low)", int'(cpu_irq_o), 0);
  endtask

  task automatic t_fixed();
    for (int p = 0; p < 4; p++) map_and_check(6, p, "R4 slot6");
    for (int p = 0; p < 4; p++) map_and_check(7, p, "R4 slot7");
  endtask

  task automatic t_expansion();
    for (int s = 8; s <= 12; s++)
      for (int p = 0; p < 4; p++) map_and_check(s, p, "R5 exp");
  endtask

  task automatic t_passthrough();
    map_and_check(0, 3, "R6 slot0");
    map_and_check(4, 1, "R6 slot4");
    map_and_check(13, 2, "R6 slot13");
    map_and_check(31, 0, "R6 slot31");
  endtask

  task automatic t_level();
    edge_mask_i = '0;
    pol_mask_i  = 32'h0000_0010;
    issue(6, 0);
    @(negedge clk);
    check("R8 level high", int'(cpu_irq_o), 1);
    repeat (3) @(negedge clk);
    check("R8 level held", int'(cpu_irq_o), 1);
    issue(7, 2);
    @(negedge clk);
    check("R8 level low", int'(cpu_irq_o), 0);
  endtask

  task automatic t_edge();
    edge_mask_i = 32'h0000_0001;
    pol_mask_i  = 32'h0000_0010;
    issue(5, 0);
    @(negedge clk);
    check("R7 pulse high", int'(cpu_irq_o), 1);
    @(negedge clk);
    check("R7 pulse over", int'(cpu_irq_o), 0);
    // pulse fired while line high by level
    issue(6, 1);
    @(negedge clk);
    check("R8 level before pulse", int'(cpu_irq_o), 1);
    issue(5, 0);
    @(negedge clk);
    check("R7 pulse on high line", int'(cpu_irq_o), 1);
    @(negedge clk);
    check("R7 line low after pulse", int'(cpu_irq_o), 0);
  endtask

  task automatic t_out_of_range();
    edge_mask_i = 32'h0000_0001;
    pol_mask_i  = 32'h0000_0010;
    issue(6, 0);
    @(negedge clk);
    check("R8 set high", int'(cpu_irq_o), 1);
    issue(3, 2);
    @(negedge clk);
    check("R9 held high", int'(cpu_irq_o), 1);
    @(negedge clk);
    check("R9 still high", int'(cpu_irq_o), 1);
    // pulse then immediate out-of-range request
    issue(7, 0);
    @(negedge clk);
    check("R8 cleared", int'(cpu_irq_o), 0);
    issue(5, 0);
    issue(1, 1);
    check("R7 pulse with oor next", int'(cpu_irq_o), 1);
    @(negedge clk);
    check("R9 pulse still ends", int'(cpu_irq_o), 0);
  endtask

  task automatic t_back_to_back();
    edge_mask_i = 32'h0000_0001;
    pol_mask_i  = 32'h0000_0010;
    issue(5, 0);
    issue(6, 3);
    check("R7 pulse first", int'(cpu_irq_o), 1);
    @(negedge clk);
    check("R8 level overrides pulse end", int'(cpu_irq_o), 1);
    @(negedge clk);
    check("R8 level kept", int'(cpu_irq_o), 1);
    issue(7, 1);
    @(negedge clk);
    check("R8 back low", int'(cpu_irq_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_south();
    t_fixed();
    t_expansion();
    t_passthrough();
    t_level();
    t_edge();
    t_out_of_range();
    t_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule